// File: doc/BRIEF.md
# Spare Row Repair Remapper

This block sits on the row address path of an embedded SRAM that has a small set of spare rows. It holds a repair register with one entry per spare row. Each entry is a valid flag and a faulty row address. Every incoming row address is compared against all valid entries in the same cycle. On a match, the block raises a spare-hit signal and names the spare row that must replace the faulty one. The array decoder uses the incoming address unchanged when there is no hit.

The repair register can be filled in two ways, and both end in the same storage. In soft mode (`hard_mode` low), a self-test engine reports failing rows after power-on. Each new failing row takes the next free entry. If no entry is free, a sticky unrepairable flag is raised. In hard mode (`hard_mode` high), a fuse bank shifts the full repair image in serially at power-up, so remapping is active without running the self-test again. In both modes `ready` stays low until loading is complete. A synchronous reset forgets everything, so each power-on starts with an empty register.

Top module: `row_repair_remap`

## Requirements
- R1: While `rst` is high at a clock edge, all entries become invalid and the allocation pointer, `unrepairable` and `ready` become 0. After that edge, `spare_hit` is 0 for every `row_addr`.
- R2: `spare_hit` and `spare_sel` follow `row_addr` combinationally, with no clock edge in between. `spare_hit` is 1 exactly when some valid entry holds `row_addr`, and `spare_sel` then gives that entry's index (0 to 3).
- R3: If several valid entries hold the same address, `spare_sel` gives the lowest entry index among them.
- R4: In soft mode, a clock edge with `bist_fail` high records `bist_fail_row` in the next free entry. Entries are used in the order 0, 1, 2, 3. An address already held by a valid entry is not recorded a second time.
- R5: In soft mode, a failing row that is not yet recorded and arrives when all four entries are used sets `unrepairable` and changes no entry. `unrepairable` then stays 1 until reset.
- R6: In soft mode, `ready` becomes 1 at the clock edge that samples `bist_done` high. `ready` then stays 1 until reset.
- R7: In hard mode, every clock edge with `fuse_en` high shifts in one `fuse_bit`. The 36-bit image arrives entry 0 first. Each entry is sent as its valid bit followed by its 8-bit address, MSB first.
- R8: In hard mode, `ready` becomes 1 at the clock edge after the one that shifted in the 36th bit. Fuse bits offered after the 36th are ignored.
- R9: In hard mode, `bist_fail` and `bist_done` have no effect. In soft mode, `fuse_en` and `fuse_bit` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hard_mode | input | 1 | 1 = load from the fuse chain, 0 = capture from self-test |
| fuse_en | input | 1 | Fuse shift enable |
| fuse_bit | input | 1 | Serial fuse data |
| bist_fail | input | 1 | Self-test fail strobe |
| bist_fail_row | input | 8 | Row address of the reported failure |
| bist_done | input | 1 | Self-test finished |
| row_addr | input | 8 | Row address of the current access |
| spare_hit | output | 1 | Access is redirected to a spare row |
| spare_sel | output | 2 | Index of the spare row used |
| ready | output | 1 | Repair loading is complete |
| unrepairable | output | 1 | A failing row found no free spare |

## Verification
A wrong entry or a misaligned fuse shift shows up as a missing, extra or wrongly indexed `spare_hit` for some row address. It appears in the first cycle after loading, so the bench sweeps all 256 addresses after each load. An allocation pointer that is off by one shows up as a failure recorded in the wrong spare or an early `unrepairable`. A wrong bit counter moves the rise of `ready` by a cycle, and the bench checks the cycle before and the cycle of the expected rise. Random fail lists with repeated addresses and random fuse images, including duplicate entries, reach the priority and full-register cases.

// File: rtl/rowfix_pkg.sv
package rowfix_pkg;

  // Total serial length of the repair image: one valid bit plus the address per spare.
  function automatic int unsigned image_len(input int unsigned spares, input int unsigned aw);
    return spares * (aw + 1);
  endfunction

  // Bit position of the valid flag of a given entry inside the flat image.
  function automatic int unsigned valid_pos(input int unsigned idx, input int unsigned spares,
                                            input int unsigned aw);
    return image_len(spares, aw) - 1 - idx * (aw + 1);
  endfunction

endpackage

// File: rtl/repair_store.sv
module repair_store
  import rowfix_pkg::*;
#(
  parameter int unsigned SPARES = 4,
  parameter int unsigned AW     = 8,
  localparam int unsigned IW    = $clog2(SPARES),
  localparam int unsigned LEN   = image_len(SPARES, AW)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  logic                   shift_bit,
  input  logic                   cap_we,
  input  logic [IW-1:0]          cap_idx,
  input  logic [AW-1:0]          cap_row,
  output logic [SPARES-1:0]      ent_valid,
  output logic [SPARES*AW-1:0]   ent_addr
);

  logic [LEN-1:0] image_q;

  // Fuse path and self-test path write the same storage.
  always_ff @(posedge clk) begin
    if (rst) begin
      image_q <= '0;
    end else if (shift_en) begin
      image_q <= {image_q[LEN-2:0], shift_bit};
    end else if (cap_we) begin
      for (int i = 0; i < SPARES; i++) begin
        if (cap_idx == IW'(i)) begin
          image_q[valid_pos(i, SPARES, AW) -: AW+1] <= {1'b1, cap_row};
        end
      end
    end
  end

  for (genvar g = 0; g < SPARES; g++) begin : g_ent
    localparam int unsigned VP = valid_pos(g, SPARES, AW);
    assign ent_valid[g]             = image_q[VP];
    assign ent_addr[g*AW +: AW]     = image_q[VP-1 -: AW];
  end

endmodule

// File: rtl/remap_match.sv
module remap_match #(
  parameter int unsigned SPARES = 4,
  parameter int unsigned AW     = 8,
  localparam int unsigned IW    = $clog2(SPARES)
) (
  input  logic [SPARES-1:0]    ent_valid,
  input  logic [SPARES*AW-1:0] ent_addr,
  input  logic [AW-1:0]        probe,
  output logic                 hit,
  output logic [IW-1:0]        sel
);

  // Scan from the top so that the lowest matching index is the last one written.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = SPARES - 1; i >= 0; i--) begin
      if (ent_valid[i] && ent_addr[i*AW +: AW] == probe) begin
        hit = 1'b1;
        sel = IW'(i);
      end
    end
  end

endmodule

// File: rtl/repair_ctl.sv
module repair_ctl
  import rowfix_pkg::*;
#(
  parameter int unsigned SPARES = 4,
  parameter int unsigned AW     = 8,
  localparam int unsigned IW    = $clog2(SPARES),
  localparam int unsigned PW    = $clog2(SPARES + 1),
  localparam int unsigned LEN   = image_len(SPARES, AW),
  localparam int unsigned CW    = $clog2(LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hard_mode,
  input  logic          fuse_en,
  input  logic          bist_fail,
  input  logic          bist_done,
  input  logic          fail_known,
  output logic          shift_en,
  output logic          cap_we,
  output logic [IW-1:0] cap_idx,
  output logic          ready,
  output logic          unrepairable
);

  localparam logic [PW-1:0] PTR_FULL = PW'(SPARES);
  localparam logic [CW-1:0] CNT_FULL = CW'(LEN);

  logic [PW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic          fail_evt;
  logic          full_evt;
  logic          load_done;

  assign shift_en  = hard_mode && fuse_en && (cnt_q != CNT_FULL);
  assign fail_evt  = !hard_mode && bist_fail && !fail_known;
  assign cap_we    = fail_evt && (ptr_q != PTR_FULL);
  assign full_evt  = fail_evt && (ptr_q == PTR_FULL);
  assign cap_idx   = ptr_q[IW-1:0];
  assign load_done = hard_mode ? (cnt_q == CNT_FULL) : bist_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q        <= '0;
      cnt_q        <= '0;
      ready        <= 1'b0;
      unrepairable <= 1'b0;
    end else begin
      if (cap_we)    ptr_q        <= ptr_q + 1'b1;
      if (shift_en)  cnt_q        <= cnt_q + 1'b1;
      if (full_evt)  unrepairable <= 1'b1;
      if (load_done) ready        <= 1'b1;
    end
  end

  assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (rst) ptr_q <= PTR_FULL);
  assert_unrep_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    unrepairable |=> unrepairable);
  assert_soft_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (!hard_mode && bist_done) |=> ready);
  assert_cnt_cap_R8: assert property (@(posedge clk) disable iff (rst) cnt_q <= CNT_FULL);
  assert_hard_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (hard_mode && cnt_q == CNT_FULL) |=> ready);
  assert_hard_no_capture_R9: assert property (@(posedge clk) disable iff (rst)
    hard_mode |=> $stable(ptr_q));
  assert_soft_no_shift_R9: assert property (@(posedge clk) disable iff (rst)
    !hard_mode |=> $stable(cnt_q));

endmodule

// File: rtl/row_repair_remap.sv
module row_repair_remap
  import rowfix_pkg::*;
#(
  parameter int unsigned SPARES = 4,
  parameter int unsigned AW     = 8,
  localparam int unsigned IW    = $clog2(SPARES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hard_mode,
  input  logic          fuse_en,
  input  logic          fuse_bit,
  input  logic          bist_fail,
  input  logic [AW-1:0] bist_fail_row,
  input  logic          bist_done,
  input  logic [AW-1:0] row_addr,
  output logic          spare_hit,
  output logic [IW-1:0] spare_sel,
  output logic          ready,
  output logic          unrepairable
);

  logic [SPARES-1:0]    ent_valid;
  logic [SPARES*AW-1:0] ent_addr;
  logic                 shift_en;
  logic                 cap_we;
  logic [IW-1:0]        cap_idx;
  logic                 fail_known;
  logic [IW-1:0]        dup_sel;

  repair_store #(.SPARES(SPARES), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .shift_en(shift_en), .shift_bit(fuse_bit),
    .cap_we(cap_we), .cap_idx(cap_idx), .cap_row(bist_fail_row),
    .ent_valid(ent_valid), .ent_addr(ent_addr)
  );

  // Access path: same-cycle compare and substitute.
  remap_match #(.SPARES(SPARES), .AW(AW)) u_access (
    .ent_valid(ent_valid), .ent_addr(ent_addr), .probe(row_addr),
    .hit(spare_hit), .sel(spare_sel)
  );

  // Capture path: detects an already recorded failing row.
  remap_match #(.SPARES(SPARES), .AW(AW)) u_dup (
    .ent_valid(ent_valid), .ent_addr(ent_addr), .probe(bist_fail_row),
    .hit(fail_known), .sel(dup_sel)
  );

  repair_ctl #(.SPARES(SPARES), .AW(AW)) u_ctl (
    .clk(clk), .rst(rst), .hard_mode(hard_mode), .fuse_en(fuse_en),
    .bist_fail(bist_fail), .bist_done(bist_done), .fail_known(fail_known),
    .shift_en(shift_en), .cap_we(cap_we), .cap_idx(cap_idx),
    .ready(ready), .unrepairable(unrepairable)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!ready && !unrepairable && ent_valid == '0));
  assert_hit_entry_R2: assert property (@(posedge clk) disable iff (rst)
    spare_hit |-> (ent_valid[spare_sel] && ent_addr[spare_sel*AW +: AW] == row_addr));
  assert_dup_seen_R4: assert property (@(posedge clk) disable iff (rst)
    fail_known |-> (ent_valid[dup_sel] && ent_addr[dup_sel*AW +: AW] == bist_fail_row));
  assert_no_rewrite_R4: assert property (@(posedge clk) disable iff (rst)
    cap_we |-> !ent_valid[cap_idx]);

endmodule

// File: tb/row_repair_remap_bench.sv
`timescale 1ns/1ps
module row_repair_remap_bench;

  logic       clk = 1'b0;
  logic       rst, hard_mode, fuse_en, fuse_bit, bist_fail, bist_done;
  logic [7:0] bist_fail_row, row_addr;
  logic       spare_hit, ready, unrepairable;
  logic [1:0] spare_sel;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bit       m_v [4];
  bit [7:0] m_a [4];
  int       m_ptr;
  bit       m_unrep;

  always #4 clk = ~clk;

  row_repair_remap u_row_repair_remap (
    .clk(clk), .rst(rst), .hard_mode(hard_mode), .fuse_en(fuse_en), .fuse_bit(fuse_bit),
    .bist_fail(bist_fail), .bist_fail_row(bist_fail_row), .bist_done(bist_done),
    .row_addr(row_addr), .spare_hit(spare_hit), .spare_sel(spare_sel),
    .ready(ready), .unrepairable(unrepairable)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected redirect: value 4 means no hit, else lowest matching index.
  function automatic int exp_sel(input bit [7:0] a);
    for (int i = 0; i < 4; i++) if (m_v[i] && m_a[i] == a) return i;
    return 4;
  endfunction

  function automatic bit [35:0] make_image(input bit [3:0] v, input bit [31:0] a);
    bit [35:0] img;
    for (int i = 0; i < 4; i++) img[35-9*i -: 9] = {v[i], a[8*i +: 8]};
    return img;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_a[i] = 0; end
    m_ptr = 0; m_unrep = 0;
  endtask

  task automatic do_reset(input bit hard);
    @(negedge clk);
    rst = 1; hard_mode = hard; fuse_en = 0; fuse_bit = 0; bist_fail = 0;
    bist_done = 0; bist_fail_row = 0; row_addr = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    model_clear();
  endtask

  task automatic probe_all(input string req);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      row_addr = 8'(a);
      #1;
      if (exp_sel(8'(a)) == 4) check(spare_hit == 0, req, spare_hit, 0);
      else check(spare_hit == 1 && spare_sel == 2'(exp_sel(8'(a))), req,
                 spare_hit ? int'(spare_sel) : 4, exp_sel(8'(a)));
    end
  endtask

  task automatic soft_fail(input bit [7:0] r);
    @(negedge clk);
    bist_fail = 1; bist_fail_row = r;
    @(negedge clk);
    bist_fail = 0;
    if (exp_sel(r) == 4) begin
      if (m_ptr < 4) begin m_v[m_ptr] = 1; m_a[m_ptr] = r; m_ptr++; end
      else m_unrep = 1;
    end
  endtask

  // Shifts a 36-bit image, entry 0 valid bit first; checks ready timing (R8).
  task automatic fuse_load(input bit [35:0] img, input bit noise);
    for (int k = 0; k < 36; k++) begin
      @(negedge clk);
      fuse_en = 1; fuse_bit = img[35-k];
      bist_fail = noise; bist_fail_row = 8'(k * 7); bist_done = noise;
    end
    @(negedge clk);
    fuse_en = 0; bist_fail = 0; bist_done = 0;
    check(ready == 0, "R8 ready early", ready, 0);
    @(negedge clk);
    check(ready == 1, "R8 ready after count", ready, 1);
    for (int i = 0; i < 4; i++) begin
      m_v[i] = img[35-9*i]; m_a[i] = img[34-9*i -: 8];
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; hard_mode = 0; fuse_en = 0; fuse_bit = 0; bist_fail = 0;
    bist_done = 0; bist_fail_row = 0; row_addr = 0;

    // R1: reset state
    do_reset(0);
    #1;
    check(ready == 0, "R1 ready", ready, 0);
    check(unrepairable == 0, "R1 unrepairable", unrepairable, 0);
    probe_all("R1 no hit after reset");

    // R4/R5 directed soft capture
    soft_fail(8'd10); soft_fail(8'd20); soft_fail(8'd10);
    soft_fail(8'd30); soft_fail(8'd40);
    #1 check(unrepairable == 0, "R5 not yet full", unrepairable, 0);
    soft_fail(8'd40);
    #1 check(unrepairable == 0, "R4 duplicate at full", unrepairable, 0);
    soft_fail(8'd50);
    #1 check(unrepairable == 1, "R5 overflow", unrepairable, 1);
    probe_all("R2 R4 soft entries");

    // R9: fuse input ignored in soft mode
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); fuse_en = 1; fuse_bit = 1;
    end
    @(negedge clk); fuse_en = 0;
    @(negedge clk);
    check(ready == 0, "R9 soft fuse ignored ready", ready, 0);
    probe_all("R9 soft fuse ignored entries");

    // R6: ready timing
    @(negedge clk); bist_done = 1;
    #1 check(ready == 0, "R6 ready before edge", ready, 0);
    @(negedge clk); bist_done = 0;
    check(ready == 1, "R6 ready after done", ready, 1);
    repeat (5) @(negedge clk);
    check(ready == 1 && unrepairable == 1, "R5 R6 sticky", {ready, unrepairable}, 3);

    // Random soft rounds
    for (int rnd = 0; rnd < 4; rnd++) begin
      do_reset(0);
      for (int n = 0; n < 1 + $urandom % 8; n++) soft_fail(8'($urandom % 6) * 8'd37);
      @(negedge clk);
      check(unrepairable == m_unrep, "R5 random soft", unrepairable, m_unrep);
      probe_all("R4 random soft");
    end

    // Hard directed: duplicates, invalid entry, noise on self-test inputs
    do_reset(1);
    fuse_load(make_image(4'b1011, {8'hFF, 8'h77, 8'h55, 8'h55}), 1);
    check(unrepairable == 0, "R9 hard fail ignored", unrepairable, 0);
    probe_all("R3 R7 hard directed");
    // R8: extra fuse bits ignored
    for (int k = 0; k < 9; k++) begin
      @(negedge clk); fuse_en = 1; fuse_bit = 1;
    end
    @(negedge clk); fuse_en = 0;
    probe_all("R8 extra fuse bits ignored");

    // Random hard rounds
    for (int rnd = 0; rnd < 4; rnd++) begin
      bit [3:0]  v;
      bit [31:0] a;
      do_reset(1);
      v = 4'($urandom);
      a = $urandom;
      if (rnd == 0) a[15:8] = a[7:0];
      fuse_load(make_image(v, a), rnd[0]);
      probe_all("R7 random hard");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule